// File: doc/BRIEF.md
# CAN Frame Transmit Serializer

This block turns one buffered standard-format CAN message into the serial bit stream that goes onto the bus. The message has an 11-bit identifier, a remote-request flag, a 4-bit length code and up to eight payload bytes. After a start request, the block sends one bit for each bit-time strobe. It builds the start-of-frame, arbitration, control, data, CRC, acknowledge and end-of-frame fields in order. Stuff bits are inserted where needed. The 15-bit CRC is worked out while the frame goes out, and the bus level is sampled at the end of the acknowledge slot to report whether any receiver acknowledged the frame.

A controller places the message on the field inputs and pulses `start_i` while the block is idle. The bit-timing logic supplies `bit_tick_i` once per nominal bit time, and the receive path supplies the sampled bus level on `bus_rx_i`. `busy_o` stays high for the whole frame. `done_o` pulses once at the end of the frame. `ack_seen_o` holds the acknowledge result until the next start.

The sequencer is a single state machine. Each state names the field whose next bit will be launched on the coming strobe:

| State | Field it launches | Leaves for | When |
|---|---|---|---|
| ST_IDLE | none | ST_SOF | start accepted |
| ST_SOF | start-of-frame | ST_IDENT | after its strobe |
| ST_IDENT | identifier | ST_RTR | after the last identifier bit |
| ST_RTR | remote-request bit | ST_CTRL | after its strobe |
| ST_CTRL | reserved bits and length code | ST_DATA or ST_CRC | ST_CRC when no data bytes are due |
| ST_DATA | payload | ST_CRC | after the last payload bit |
| ST_CRC | CRC sequence | ST_CRC_DLM | after the last CRC bit |
| ST_CRC_DLM | CRC delimiter | ST_ACK_SLOT | after its strobe |
| ST_ACK_SLOT | acknowledge slot | ST_ACK_DLM | after its strobe |
| ST_ACK_DLM | acknowledge delimiter | ST_EOF | after its strobe (the bus level is sampled here) |
| ST_EOF | end-of-frame | ST_TAIL | after the last end-of-frame bit |
| ST_TAIL | none | ST_IDLE | on the strobe that closes the last bit |

A strobe that comes while a stuff bit is owed launches the stuff bit, and the state and bit index do not move on that strobe.

Top module: `can_tx_serializer`

## Requirements
- R1: After reset, and whenever it is not busy, the block drives `tx_bit_o` recessive (1) with `busy_o` and `done_o` low. A `start_i` pulse that arrives while `busy_o` is high is ignored and does not change the frame in flight.
- R2: A start is accepted only in idle, and `busy_o` rises on the next clock. `tx_bit_o` changes only on a clock edge where `bit_tick_i` is high. The first strobe after the start launches the start-of-frame bit, which is dominant (0).
- R3: The identifier follows start-of-frame, most significant bit first. Then comes the remote-request bit: 1 for a remote frame and 0 for a data frame.
- R4: The control field is six bits. It starts with two dominant (0) reserved bits, followed by the 4-bit length code, most significant bit first.
- R5: A data frame carries min(length code, 8) payload bytes, and a remote frame carries none. Byte k is `payload_i[8k+7:8k]`. Byte 0 is sent first, and each byte goes out most significant bit first.
- R6: The CRC uses the polynomial 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1) and starts from zero. It covers the unstuffed bits from start-of-frame through the last data bit. It is sent as 15 bits, most significant bit first, followed by one recessive delimiter.
- R7: From start-of-frame through the last CRC bit, stuff bits count toward the run length. After five equal consecutive bits, one bit of the opposite level is inserted. This includes the position right after the final CRC bit.
- R8: The acknowledge slot and the acknowledge delimiter are both driven recessive. `ack_seen_o` is cleared when a start is accepted. It is set if `bus_rx_i` is low on the strobe that ends the slot, and it holds until the next start.
- R9: End-of-frame is seven recessive bits. From the CRC delimiter onward, no stuff bit is inserted.
- R10: On the strobe that ends the last end-of-frame bit, `done_o` pulses high for exactly one clock, and `busy_o` falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send the presented message |
| ident_i | input | 11 | Identifier |
| remote_i | input | 1 | 1 = remote frame, 0 = data frame |
| dlc_i | input | 4 | Length code |
| payload_i | input | 64 | Payload; byte k in bits 8k+7:8k |
| bit_tick_i | input | 1 | One-clock strobe per bit time |
| bus_rx_i | input | 1 | Sampled bus level |
| tx_bit_o | output | 1 | Transmit bit (1 = recessive) |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-clock end-of-frame pulse |
| ack_seen_o | output | 1 | A receiver drove the acknowledge slot dominant |

## Verification
The bench aims at the stuffing corners. An all-zero identifier with a zero length code produces long dominant runs, an all-ones identifier on a remote frame produces long recessive runs, and all-0xFF payloads exercise stuffing inside the data field. Any of these would expose a design that counts runs without the stuff bits, or that skips the stuff bit owed after the last CRC bit: the stream would slip by one bit and every later bit would mismatch. A length code of 15 checks the cap at eight bytes; a design without the cap would send extra bytes. A remote frame with a nonzero length code checks that no data is sent. Frames are run both with and without a dominant acknowledge pulled at the slot, which catches a flag sampled one bit early or late. A second start request in the middle of a frame catches a design that reloads its buffer while busy.

// File: rtl/cantx_pkg.sv
package cantx_pkg;

    localparam int RSV_BITS = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SOF,
        ST_IDENT,
        ST_RTR,
        ST_CTRL,
        ST_DATA,
        ST_CRC,
        ST_CRC_DLM,
        ST_ACK_SLOT,
        ST_ACK_DLM,
        ST_EOF,
        ST_TAIL
    } tx_state_t;

endpackage

// File: rtl/cantx_crc.sv
module cantx_crc #(
    parameter int             CRC_W    = 15,
    parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);

    logic             fb;
    logic [CRC_W-1:0] crc_d;

    always_comb begin
        fb    = bit_i ^ crc_o[CRC_W-1];
        crc_d = {crc_o[CRC_W-2:0], 1'b0};
        if (fb) begin
            crc_d = crc_d ^ CRC_POLY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_o <= '0;
        end else if (clear_i) begin
            crc_o <= '0;
        end else if (shift_i) begin
            crc_o <= crc_d;
        end
    end

    // R6: the register moves only when a covered bit is shifted in
    a_r6_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clear_i) |=> $stable(crc_o));

endmodule

// File: rtl/cantx_stuff.sv
module cantx_stuff #(
    parameter int STUFF_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic emit_i,
    input  logic bit_i,
    input  logic zone_i,
    output logic stuff_req_o,
    output logic stuff_bit_o
);

    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    logic             last_q;
    logic             zone_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b1;
            zone_q <= 1'b0;
            run_q  <= '0;
        end else if (clear_i) begin
            last_q <= 1'b1;
            zone_q <= 1'b0;
            run_q  <= '0;
        end else if (emit_i) begin
            last_q <= bit_i;
            zone_q <= zone_i;
            if (bit_i == last_q && run_q != RUN_W'(STUFF_RUN)) begin
                run_q <= run_q + RUN_W'(1);
            end else begin
                run_q <= RUN_W'(1);
            end
        end
    end

    assign stuff_req_o = zone_q && (run_q == RUN_W'(STUFF_RUN));
    assign stuff_bit_o = ~last_q;

    // R7: when a stuff bit is owed, the sequencer must launch the opposite level
    a_r7_stuff_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_i && stuff_req_o) |-> (bit_i != last_q));

    // R7: the run counter never passes the stuff width
    a_r7_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(STUFF_RUN));

endmodule

// File: rtl/cantx_bitsel.sv
module cantx_bitsel
    import cantx_pkg::*;
#(
    parameter int ID_W      = 11,
    parameter int DLC_W     = 4,
    parameter int MAX_BYTES = 8,
    parameter int CRC_W     = 15,
    parameter int IDX_W     = 7
) (
    input  tx_state_t                  state_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [ID_W-1:0]            ident_i,
    input  logic                       remote_i,
    input  logic [DLC_W-1:0]           dlc_i,
    input  logic [MAX_BYTES*8-1:0]     payload_i,
    input  logic [CRC_W-1:0]           crc_i,
    output logic                       raw_bit_o,
    output logic                       zone_o,
    output logic                       crc_en_o
);

    localparam int PAY_W  = MAX_BYTES * 8;
    localparam int PAY_IW = $clog2(PAY_W);
    localparam int CTRL_W = RSV_BITS + DLC_W;

    logic [ID_W-1:0]   id_sh;
    logic [CTRL_W-1:0] ctrl_sh;
    logic [CRC_W-1:0]  crc_sh;
    logic [PAY_IW-1:0] pidx;

    always_comb begin
        id_sh     = ident_i << idx_i;
        ctrl_sh   = {{RSV_BITS{1'b0}}, dlc_i} << idx_i;
        crc_sh    = crc_i << idx_i;
        pidx      = {idx_i[PAY_IW-1:3], ~idx_i[2:0]};
        raw_bit_o = 1'b1;
        zone_o    = 1'b0;
        crc_en_o  = 1'b0;
        unique case (state_i)
            ST_SOF: begin
                raw_bit_o = 1'b0;
                zone_o    = 1'b1;
                crc_en_o  = 1'b1;
            end
            ST_IDENT: begin
                raw_bit_o = id_sh[ID_W-1];
                zone_o    = 1'b1;
                crc_en_o  = 1'b1;
            end
            ST_RTR: begin
                raw_bit_o = remote_i;
                zone_o    = 1'b1;
                crc_en_o  = 1'b1;
            end
            ST_CTRL: begin
                raw_bit_o = ctrl_sh[CTRL_W-1];
                zone_o    = 1'b1;
                crc_en_o  = 1'b1;
            end
            ST_DATA: begin
                raw_bit_o = payload_i[pidx];
                zone_o    = 1'b1;
                crc_en_o  = 1'b1;
            end
            ST_CRC: begin
                raw_bit_o = crc_sh[CRC_W-1];
                zone_o    = 1'b1;
            end
            ST_IDLE, ST_CRC_DLM, ST_ACK_SLOT, ST_ACK_DLM, ST_EOF, ST_TAIL: begin
                raw_bit_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/can_tx_serializer.sv
module can_tx_serializer
    import cantx_pkg::*;
#(
    parameter int               ID_W      = 11,
    parameter int               DLC_W     = 4,
    parameter int               MAX_BYTES = 8,
    parameter int               CRC_W     = 15,
    parameter logic [CRC_W-1:0] CRC_POLY  = 15'h4599,
    parameter int               STUFF_RUN = 5,
    parameter int               EOF_BITS  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ID_W-1:0]        ident_i,
    input  logic                   remote_i,
    input  logic [DLC_W-1:0]       dlc_i,
    input  logic [MAX_BYTES*8-1:0] payload_i,
    input  logic                   bit_tick_i,
    input  logic                   bus_rx_i,
    output logic                   tx_bit_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   ack_seen_o
);

    localparam int PAY_W  = MAX_BYTES * 8;
    localparam int CTRL_W = RSV_BITS + DLC_W;
    localparam int IDX_W  = $clog2(PAY_W + ID_W + CRC_W + EOF_BITS + CTRL_W);
    localparam int NB_W   = $clog2(MAX_BYTES + 1);

    tx_state_t          state_q, state_d;
    logic [IDX_W-1:0]   idx_q, idx_d;

    logic [ID_W-1:0]    ident_q;
    logic               remote_q;
    logic [DLC_W-1:0]   dlc_q;
    logic [PAY_W-1:0]   payload_q;
    logic [NB_W-1:0]    nbytes_q;

    logic               accept;
    logic               emit;
    logic               advance;
    logic               emit_bit;
    logic               emit_zone;
    logic               raw_bit;
    logic               raw_zone;
    logic               raw_crc_en;
    logic               stuff_req;
    logic               stuff_bit;
    logic [CRC_W-1:0]   crc_val;
    logic [IDX_W-1:0]   data_last;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign emit      = bit_tick_i && (state_q != ST_IDLE) && (state_q != ST_TAIL);
    assign advance   = bit_tick_i && !stuff_req;
    assign emit_bit  = stuff_req ? stuff_bit : raw_bit;
    assign emit_zone = stuff_req ? 1'b1 : raw_zone;
    assign data_last = (IDX_W'(nbytes_q) << 3) - IDX_W'(1);

    cantx_bitsel #(
        .ID_W      (ID_W),
        .DLC_W     (DLC_W),
        .MAX_BYTES (MAX_BYTES),
        .CRC_W     (CRC_W),
        .IDX_W     (IDX_W)
    ) u_bitsel (
        .state_i   (state_q),
        .idx_i     (idx_q),
        .ident_i   (ident_q),
        .remote_i  (remote_q),
        .dlc_i     (dlc_q),
        .payload_i (payload_q),
        .crc_i     (crc_val),
        .raw_bit_o (raw_bit),
        .zone_o    (raw_zone),
        .crc_en_o  (raw_crc_en)
    );

    cantx_stuff #(
        .STUFF_RUN (STUFF_RUN)
    ) u_stuff (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .emit_i      (emit),
        .bit_i       (emit_bit),
        .zone_i      (emit_zone),
        .stuff_req_o (stuff_req),
        .stuff_bit_o (stuff_bit)
    );

    cantx_crc #(
        .CRC_W    (CRC_W),
        .CRC_POLY (CRC_POLY)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .shift_i (emit && !stuff_req && raw_crc_en),
        .bit_i   (raw_bit),
        .crc_o   (crc_val)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SOF;
                    idx_d   = '0;
                end
            end
            ST_SOF: begin
                if (advance) begin
                    state_d = ST_IDENT;
                    idx_d   = '0;
                end
            end
            ST_IDENT: begin
                if (advance) begin
                    if (idx_q == IDX_W'(ID_W - 1)) begin
                        state_d = ST_RTR;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_RTR: begin
                if (advance) begin
                    state_d = ST_CTRL;
                    idx_d   = '0;
                end
            end
            ST_CTRL: begin
                if (advance) begin
                    if (idx_q == IDX_W'(CTRL_W - 1)) begin
                        state_d = (nbytes_q == '0) ? ST_CRC : ST_DATA;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (advance) begin
                    if (idx_q == data_last) begin
                        state_d = ST_CRC;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_CRC: begin
                if (advance) begin
                    if (idx_q == IDX_W'(CRC_W - 1)) begin
                        state_d = ST_CRC_DLM;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_CRC_DLM: begin
                if (advance) begin
                    state_d = ST_ACK_SLOT;
                end
            end
            ST_ACK_SLOT: begin
                if (advance) begin
                    state_d = ST_ACK_DLM;
                end
            end
            ST_ACK_DLM: begin
                if (advance) begin
                    state_d = ST_EOF;
                    idx_d   = '0;
                end
            end
            ST_EOF: begin
                if (advance) begin
                    if (idx_q == IDX_W'(EOF_BITS - 1)) begin
                        state_d = ST_TAIL;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_TAIL: begin
                if (bit_tick_i) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // state register and message buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            ident_q   <= '0;
            remote_q  <= 1'b0;
            dlc_q     <= '0;
            payload_q <= '0;
            nbytes_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept) begin
                ident_q   <= ident_i;
                remote_q  <= remote_i;
                dlc_q     <= dlc_i;
                payload_q <= payload_i;
                if (remote_i) begin
                    nbytes_q <= '0;
                end else if (dlc_i > DLC_W'(MAX_BYTES)) begin
                    nbytes_q <= NB_W'(MAX_BYTES);
                end else begin
                    nbytes_q <= NB_W'(dlc_i);
                end
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit_o   <= 1'b1;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            ack_seen_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                busy_o     <= 1'b1;
                ack_seen_o <= 1'b0;
            end
            if (emit) begin
                tx_bit_o <= emit_bit;
            end
            if (bit_tick_i && state_q == ST_ACK_DLM) begin
                ack_seen_o <= ~bus_rx_i;
            end
            if (bit_tick_i && state_q == ST_TAIL) begin
                tx_bit_o <= 1'b1;
                busy_o   <= 1'b0;
                done_o   <= 1'b1;
            end
        end
    end

    // R1: nothing but recessive leaves the block while it is not busy
    a_r1_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_bit_o);

    // R1: a request while busy leaves the buffer untouched
    a_r1_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(payload_q) && $stable(ident_q)));

    // R2: the wire only moves on a strobe edge
    a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick_i |=> $stable(tx_bit_o));

    // R2: busy follows an accepted start
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    // R8, R9: acknowledge field and end-of-frame are recessive
    a_r9_tail_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick_i && (state_q inside {ST_ACK_SLOT, ST_ACK_DLM, ST_EOF})) |=> tx_bit_o);

    // R8: the acknowledge flag moves only at start or at the end of the slot
    a_r8_ack_sample_point: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !(bit_tick_i && state_q == ST_ACK_DLM)) |=> $stable(ack_seen_o));

    // R10: done is a single-clock pulse that ends busy
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/can_tx_serializer_test.sv
module can_tx_serializer_test;

    typedef struct {
        logic  b;
        logic  slot;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] ident_i = '0;
    logic        remote_i = 1'b0;
    logic [3:0]  dlc_i = '0;
    logic [63:0] payload_i = '0;
    logic        bit_tick_i = 1'b0;
    logic        bus_rx_i;
    logic        tx_bit_o;
    logic        busy_o;
    logic        done_o;
    logic        ack_seen_o;

    int   total = 0;
    int   bad = 0;
    exp_t exp_q[$];
    logic frame_active = 1'b0;
    logic tick_edge = 1'b0;
    logic ack_en = 1'b0;
    logic ack_pull = 1'b0;
    int   tcnt = 0;

    always #2 clk = ~clk;

    assign bus_rx_i = tx_bit_o & ~ack_pull;

    can_tx_serializer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ident_i    (ident_i),
        .remote_i   (remote_i),
        .dlc_i      (dlc_i),
        .payload_i  (payload_i),
        .bit_tick_i (bit_tick_i),
        .bus_rx_i   (bus_rx_i),
        .tx_bit_o   (tx_bit_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ack_seen_o (ack_seen_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    always @(posedge clk) tick_edge <= bit_tick_i && frame_active;

    // monitor (scoreboard pop) and strobe generator, both away from the rising edge
    always @(negedge clk) begin
        if (tick_edge) begin
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(tx_bit_o === e.b, e.tag, 64'(tx_bit_o), 64'(e.b));
                chk(busy_o === 1'b1, "R10 busy in frame", 64'(busy_o), 64'd1);
                ack_pull = e.slot && ack_en;
            end else begin
                chk(done_o === 1'b1, "R10 done pulse", 64'(done_o), 64'd1);
                chk(busy_o === 1'b0, "R10 busy drop", 64'(busy_o), 64'd0);
                ack_pull = 1'b0;
                frame_active = 1'b0;
            end
        end
        tcnt = (tcnt + 1) % 4;
        bit_tick_i = (tcnt == 0);
    end

    task automatic send_frame(input logic [10:0] id, input logic rem, input logic [3:0] dlc,
                              input logic [63:0] pay, input logic ack, input logic poke);
        logic  raw[$];
        string rtag[$];
        logic [14:0] crc;
        int nb;
        int run;
        logic last;
        exp_t e;
        raw.push_back(1'b0); rtag.push_back("R2 sof");
        for (int i = 10; i >= 0; i--) begin raw.push_back(id[i]); rtag.push_back("R3 ident"); end
        raw.push_back(rem); rtag.push_back("R3 rtr");
        raw.push_back(1'b0); rtag.push_back("R4 reserved");
        raw.push_back(1'b0); rtag.push_back("R4 reserved");
        for (int i = 3; i >= 0; i--) begin raw.push_back(dlc[i]); rtag.push_back("R4 dlc"); end
        nb = rem ? 0 : ((dlc > 8) ? 8 : int'(dlc));
        for (int k = 0; k < nb; k++)
            for (int i = 7; i >= 0; i--) begin raw.push_back(pay[8*k+i]); rtag.push_back("R5 data"); end
        crc = '0;
        foreach (raw[j]) begin
            logic fb;
            fb  = raw[j] ^ crc[14];
            crc = {crc[13:0], 1'b0};
            if (fb) crc = crc ^ 15'h4599;
        end
        for (int i = 14; i >= 0; i--) begin raw.push_back(crc[i]); rtag.push_back("R6 crc"); end
        run = 0;
        last = 1'b1;
        foreach (raw[j]) begin
            if (run == 5) begin
                e.b = ~last; e.slot = 1'b0; e.tag = "R7 stuff";
                exp_q.push_back(e);
                last = ~last;
                run = 1;
            end
            e.b = raw[j]; e.slot = 1'b0; e.tag = rtag[j];
            exp_q.push_back(e);
            if (raw[j] == last) run++; else run = 1;
            last = raw[j];
        end
        if (run == 5) begin
            e.b = ~last; e.slot = 1'b0; e.tag = "R7 stuff after crc";
            exp_q.push_back(e);
        end
        e.b = 1'b1; e.slot = 1'b0; e.tag = "R6 crc delimiter"; exp_q.push_back(e);
        e.b = 1'b1; e.slot = 1'b1; e.tag = "R8 ack slot";      exp_q.push_back(e);
        e.b = 1'b1; e.slot = 1'b0; e.tag = "R8 ack delimiter"; exp_q.push_back(e);
        for (int i = 0; i < 7; i++) begin
            e.b = 1'b1; e.slot = 1'b0; e.tag = "R9 eof"; exp_q.push_back(e);
        end

        @(negedge clk);
        ack_en    = ack;
        ident_i   = id;
        remote_i  = rem;
        dlc_i     = dlc;
        payload_i = pay;
        start_i   = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        frame_active = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
        if (poke) begin
            repeat (60) @(negedge clk);
            ident_i   = ~id;
            remote_i  = ~rem;
            dlc_i     = 4'd1;
            payload_i = ~pay;
            start_i   = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (frame_active == 1'b0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R10 frame length", 64'(exp_q.size()), 64'd0);
        chk(ack_seen_o === ack, "R8 ack flag", 64'(ack_seen_o), 64'(ack));
        chk(done_o === 1'b0, "R10 done one clock", 64'(done_o), 64'd0);
        repeat (9) @(negedge clk);
        chk(tx_bit_o === 1'b1, "R1 idle recessive", 64'(tx_bit_o), 64'd1);
        chk(busy_o === 1'b0, "R1 idle not busy", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_bit_o === 1'b1, "R1 reset tx", 64'(tx_bit_o), 64'd1);
        chk(busy_o === 1'b0, "R1 reset busy", 64'(busy_o), 64'd0);
        chk(done_o === 1'b0, "R1 reset done", 64'(done_o), 64'd0);
        chk(ack_seen_o === 1'b0, "R8 reset ack", 64'(ack_seen_o), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        send_frame(11'h123, 1'b0, 4'd2, 64'h0000_0000_0000_0FA5, 1'b1, 1'b1);
        send_frame(11'h7FF, 1'b1, 4'd4, 64'hDEAD_BEEF_0123_4567, 1'b0, 1'b0);
        send_frame(11'h000, 1'b0, 4'd0, 64'h0, 1'b1, 1'b0);
        send_frame(11'h555, 1'b0, 4'd8, 64'h7766_5544_3322_1100, 1'b1, 1'b0);
        send_frame(11'h0F0, 1'b0, 4'd15, 64'h0102_0408_1020_4080, 1'b0, 1'b0);
        send_frame(11'h3C1, 1'b0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        send_frame(11'h001, 1'b1, 4'd0, 64'h0, 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule